// File: doc/BRIEF.md
# 2B1Q Superframe Transmit Framer

This block assembles the downstream line superframe of a 2B1Q digital subscriber loop as a stream of quats, one quat per clock cycle. It keeps track of the quat position inside a 120-quat basic frame and the basic-frame position inside an 8-frame superframe. For each position it chooses one of three sources: the 9-quat synchronisation pattern (inverted in the first frame of a superframe), a 2B+D payload quat from an upstream mapper, or overhead bits. The overhead bits are taken from a 12-bit embedded-operations word, four maintenance flags, a far-end block error bit and a 12-bit CRC supplied by a companion unit.

Each output quat is a sign/magnitude bit pair. The sign bit goes on the line first. Quat values are encoded as {sign,mag}: 10 = +3, 11 = +1, 01 = -1, 00 = -3. A scramble-enable flag goes with every quat, so that a downstream scrambler leaves the sync pattern untouched. A strobe marks the first quat of every superframe. The mapper is told one cycle ahead when a payload quat will be taken.

Top module: `sfr_tx_framer`

## Requirements
- R1: While rst_n is low, tx_sign, tx_mag, tx_scr and sf_start are 0. The first quat driven after reset is quat 1 of frame 1, and it comes with sf_start high.
- R2: A basic frame lasts 120 cycles and a superframe lasts 8 basic frames. sf_start is high for one cycle in every 960, on quat 1 of frame 1 only.
- R3: Quats 1–9 of frames 2–8 carry the sync pattern SYNC_PAT, with quat 1 in bits [17:16] (default +3 +3 -3 -3 -3 +3 -3 +3 +3). In frame 1 each of these quats is negated, meaning the sign bit is inverted and the magnitude kept.
- R4: pay_req is high in exactly the cycles that come before quats 10–117. The quat driven in the next cycle equals {pay_sign,pay_mag} as sampled in the pay_req cycle.
- R5: tx_scr is 0 on quats 1–9 and 1 on every other quat.
- R6: The eoc word is laid out as bit 11 = a1, 10 = a2, 9 = a3, 8 = dm, 7..0 = i1..i8. In frame k (k taken modulo 4, counting from 0), quat 118 sign = bit 11-3k, quat 118 mag = bit 10-3k and quat 119 sign = bit 9-3k.
- R7: The eoc word is sampled only on the clock edge that drives quat 1 of frame 1 and quat 1 of frame 5. A change at any other time has no effect on the quats sent until the next of those edges.
- R8: The quat 119 magnitude bit is act in frame 1, dea in frame 6, uoa in frame 7, aib in frame 8, and 1 in frames 2–5.
- R9: Quat 120 is {1,1} in frame 1 and {1,febe} in frame 2.
- R10: In frame f, for f from 3 to 8, quat 120 sign = crc_bits[11-2(f-3)] and quat 120 mag = crc_bits[10-2(f-3)]. crc_bits[11] is CRC bit 1, the most significant bit.
- R11: The flag, febe and CRC inputs are sampled on the clock edge that drives the quat carrying them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Quat clock, one quat per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| eoc_word | input | 12 | Embedded operations word (a1 in bit 11) |
| act_bit | input | 1 | Activation bit |
| dea_bit | input | 1 | Deactivation bit |
| uoa_bit | input | 1 | U-only activation bit |
| aib_bit | input | 1 | Alarm indication bit |
| febe_bit | input | 1 | Far-end block error bit |
| crc_bits | input | 12 | CRC of the previous superframe, bit 11 = CRC bit 1 |
| pay_sign | input | 1 | Payload quat sign bit from the mapper |
| pay_mag | input | 1 | Payload quat magnitude bit from the mapper |
| pay_req | output | 1 | Payload quat will be taken at the next edge |
| tx_sign | output | 1 | Outgoing quat sign bit (sent first) |
| tx_mag | output | 1 | Outgoing quat magnitude bit |
| tx_scr | output | 1 | Outgoing quat is to be scrambled |
| sf_start | output | 1 | First quat of a superframe |

## Verification
The payload assertion assumes that the mapper holds pay_sign and pay_mag at known values through each cycle in which pay_req is high. The period and wrap assertions assume that reset is held for at least one clock edge before the stream starts. The bench changes every input only on the falling clock edge, drives the payload from a running LFSR so that it is never unknown, and releases reset after several cycles. It also changes the eoc word in the middle of frames, to show that those changes have no effect.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
    localparam int SF_FRAMES   = 8;
    localparam int FRAME_IDX_W = 3;
    localparam int EOC_W       = 12;
    localparam int CRC_W       = 12;

    typedef struct packed {
        logic sgn;
        logic mag;
    } quat_t;
endpackage

// File: rtl/sfr_pos_ctr.sv
module sfr_pos_ctr
    import sfr_pkg::*;
#(
    parameter int FRAME_QUATS = 120,
    parameter int QW          = $clog2(FRAME_QUATS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    output logic [QW-1:0]          quat_nx,
    output logic [FRAME_IDX_W-1:0] frame_nx
);
    localparam logic [QW-1:0]          LAST_Q = QW'(FRAME_QUATS - 1);
    localparam logic [FRAME_IDX_W-1:0] LAST_F = FRAME_IDX_W'(SF_FRAMES - 1);

    typedef struct packed {
        logic [QW-1:0]          quat;
        logic [FRAME_IDX_W-1:0] frame;
    } pos_t;

    pos_t pos_d, pos_q;

    always_comb begin
        pos_d = pos_q;
        if (pos_q.quat == LAST_Q) begin
            pos_d.quat  = '0;
            pos_d.frame = (pos_q.frame == LAST_F) ? '0 : pos_q.frame + 1'b1;
        end else begin
            pos_d.quat = pos_q.quat + 1'b1;
        end
    end

    // reset parks on the last position so the first step lands on frame 1 quat 1
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '{quat: LAST_Q, frame: LAST_F};
        end else begin
            pos_q <= pos_d;
        end
    end

    assign quat_nx  = pos_d.quat;
    assign frame_nx = pos_d.frame;

    a_r2_quat_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q.quat == LAST_Q) |=> (pos_q.quat == '0));
    a_r2_frame_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q.quat != LAST_Q) |=> $stable(pos_q.frame));
    a_r2_sf_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q.quat == LAST_Q && pos_q.frame == LAST_F) |=> (pos_q.frame == '0));
endmodule

// File: rtl/sfr_sync_sel.sv
module sfr_sync_sel
    import sfr_pkg::*;
#(
    parameter int               SYNC_LEN = 9,
    parameter int               QW       = 7,
    parameter logic [2*SYNC_LEN-1:0] SYNC_PAT = 18'b10_10_00_00_00_10_00_10_10
) (
    input  logic [QW-1:0] quat_idx,
    input  logic          invert,
    output quat_t         sync_quat
);
    quat_t pat_arr [SYNC_LEN];

    for (genvar g = 0; g < SYNC_LEN; g++) begin : g_unpack
        assign pat_arr[g] = quat_t'(SYNC_PAT[2*(SYNC_LEN-1-g) +: 2]);
    end

    always_comb begin
        sync_quat = '0;
        for (int i = 0; i < SYNC_LEN; i++) begin
            if (quat_idx == QW'(i)) begin
                sync_quat = pat_arr[i];
            end
        end
        sync_quat.sgn = sync_quat.sgn ^ invert;
    end
endmodule

// File: rtl/sfr_ovh_map.sv
module sfr_ovh_map
    import sfr_pkg::*;
(
    input  logic [FRAME_IDX_W-1:0] frame,
    input  logic [1:0]             slot,
    input  logic [EOC_W-1:0]       eoc,
    input  logic                   act_bit,
    input  logic                   dea_bit,
    input  logic                   uoa_bit,
    input  logic                   aib_bit,
    input  logic                   febe_bit,
    input  logic [CRC_W-1:0]       crc_bits,
    output quat_t                  ovh_quat
);
    int   eoc_base;
    int   crc_base;
    logic m4_bit;

    always_comb begin
        // eoc fields rotate every four frames, three bits per frame
        eoc_base = EOC_W - 1 - 3 * int'(frame[1:0]);
        crc_base = CRC_W - 1 - 2 * (int'(frame) - 2);
        if (crc_base < 1) begin
            crc_base = 1;
        end

        unique case (frame)
            3'd0:    m4_bit = act_bit;
            3'd5:    m4_bit = dea_bit;
            3'd6:    m4_bit = uoa_bit;
            3'd7:    m4_bit = aib_bit;
            default: m4_bit = 1'b1;
        endcase

        ovh_quat = '{sgn: 1'b1, mag: 1'b1};
        case (slot)
            2'd0: ovh_quat = '{sgn: eoc[eoc_base], mag: eoc[eoc_base-1]};
            2'd1: ovh_quat = '{sgn: eoc[eoc_base-2], mag: m4_bit};
            default: begin
                if (frame == 3'd0) begin
                    ovh_quat = '{sgn: 1'b1, mag: 1'b1};
                end else if (frame == 3'd1) begin
                    ovh_quat = '{sgn: 1'b1, mag: febe_bit};
                end else begin
                    ovh_quat = '{sgn: crc_bits[crc_base], mag: crc_bits[crc_base-1]};
                end
            end
        endcase
    end
endmodule

// File: rtl/sfr_tx_framer.sv
module sfr_tx_framer
    import sfr_pkg::*;
#(
    parameter int                    FRAME_QUATS = 120,
    parameter int                    SYNC_LEN    = 9,
    parameter int                    OVH_QUATS   = 3,
    parameter logic [2*SYNC_LEN-1:0] SYNC_PAT    = 18'b10_10_00_00_00_10_00_10_10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EOC_W-1:0] eoc_word,
    input  logic             act_bit,
    input  logic             dea_bit,
    input  logic             uoa_bit,
    input  logic             aib_bit,
    input  logic             febe_bit,
    input  logic [CRC_W-1:0] crc_bits,
    input  logic             pay_sign,
    input  logic             pay_mag,
    output logic             pay_req,
    output logic             tx_sign,
    output logic             tx_mag,
    output logic             tx_scr,
    output logic             sf_start
);
    localparam int            QW       = $clog2(FRAME_QUATS);
    localparam int            SF_QUATS = FRAME_QUATS * SF_FRAMES;
    localparam int            GW       = $clog2(SF_QUATS + 1);
    localparam logic [QW-1:0] PAY_LO   = QW'(SYNC_LEN);
    localparam logic [QW-1:0] OVH_LO   = QW'(FRAME_QUATS - OVH_QUATS);
    localparam logic [QW-1:0] PAY_HI   = QW'(FRAME_QUATS - OVH_QUATS - 1);

    typedef struct packed {
        quat_t            tx;
        logic             scr;
        logic             sfs;
        logic [EOC_W-1:0] eoc;
    } st_t;

    st_t st_d, st_q;

    logic [QW-1:0]          quat_nx;
    logic [FRAME_IDX_W-1:0] frame_nx;
    quat_t                  sync_quat;
    quat_t                  ovh_quat;
    logic [1:0]             ovh_slot;
    logic                   in_sync;
    logic                   in_pay;
    logic                   eoc_load;

    sfr_pos_ctr #(
        .FRAME_QUATS (FRAME_QUATS),
        .QW          (QW)
    ) pos_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .quat_nx  (quat_nx),
        .frame_nx (frame_nx)
    );

    sfr_sync_sel #(
        .SYNC_LEN (SYNC_LEN),
        .QW       (QW),
        .SYNC_PAT (SYNC_PAT)
    ) sync_i (
        .quat_idx  (quat_nx),
        .invert    (frame_nx == '0),
        .sync_quat (sync_quat)
    );

    sfr_ovh_map ovh_i (
        .frame    (frame_nx),
        .slot     (ovh_slot),
        .eoc      (st_q.eoc),
        .act_bit  (act_bit),
        .dea_bit  (dea_bit),
        .uoa_bit  (uoa_bit),
        .aib_bit  (aib_bit),
        .febe_bit (febe_bit),
        .crc_bits (crc_bits),
        .ovh_quat (ovh_quat)
    );

    always_comb begin
        in_sync  = (quat_nx < PAY_LO);
        in_pay   = (quat_nx >= PAY_LO) && (quat_nx <= PAY_HI);
        ovh_slot = (quat_nx == OVH_LO)        ? 2'd0 :
                   (quat_nx == OVH_LO + 1'b1) ? 2'd1 : 2'd2;
        eoc_load = (quat_nx == '0) && (frame_nx[1:0] == 2'b00);

        st_d     = st_q;
        st_d.sfs = (quat_nx == '0) && (frame_nx == '0);
        if (in_sync) begin
            st_d.tx  = sync_quat;
            st_d.scr = 1'b0;
        end else if (in_pay) begin
            st_d.tx  = '{sgn: pay_sign, mag: pay_mag};
            st_d.scr = 1'b1;
        end else begin
            st_d.tx  = ovh_quat;
            st_d.scr = 1'b1;
        end
        if (eoc_load) begin
            st_d.eoc = eoc_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pay_req  = in_pay;
    assign tx_sign  = st_q.tx.sgn;
    assign tx_mag   = st_q.tx.mag;
    assign tx_scr   = st_q.scr;
    assign sf_start = st_q.sfs;

    // checker state: cycles elapsed since the last superframe strobe
    logic [GW-1:0] gap_q;
    logic          seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (sf_start) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else begin
            gap_q  <= gap_q + 1'b1;
        end
    end

    a_r2_sf_period: assert property (@(posedge clk) disable iff (!rst_n)
        (sf_start && seen_q) |-> (gap_q == GW'(SF_QUATS - 1)));
    a_r5_sync_clear: assert property (@(posedge clk) disable iff (!rst_n)
        sf_start |-> !tx_scr);
    a_r4_payload_pass: assert property (@(posedge clk) disable iff (!rst_n)
        pay_req |=> (tx_scr && tx_sign == $past(pay_sign) && tx_mag == $past(pay_mag)));
    a_r7_eoc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !eoc_load |=> $stable(st_q.eoc));
endmodule

// File: tb/sfr_tx_framer_tb.sv
module sfr_tx_framer_tb_top;
    localparam logic [17:0] PAT = 18'b10_10_00_00_00_10_00_10_10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] eoc_word = '0;
    logic        act_bit = 1'b0, dea_bit = 1'b0, uoa_bit = 1'b0, aib_bit = 1'b0;
    logic        febe_bit = 1'b0;
    logic [11:0] crc_bits = '0;
    logic        pay_sign = 1'b0, pay_mag = 1'b0;
    logic        pay_req, tx_sign, tx_mag, tx_scr, sf_start;

    int n_chk = 0;
    int n_bad = 0;

    int          bq = 119;
    int          bf = 7;
    logic [11:0] exp_eoc = '0;
    logic [15:0] lfsr = 16'hACE1;
    int          last_sf = -1;
    int          cyc = 0;

    always #2.5 clk = ~clk;

    sfr_tx_framer dut_i (
        .clk (clk), .rst_n (rst_n), .eoc_word (eoc_word),
        .act_bit (act_bit), .dea_bit (dea_bit), .uoa_bit (uoa_bit),
        .aib_bit (aib_bit), .febe_bit (febe_bit), .crc_bits (crc_bits),
        .pay_sign (pay_sign), .pay_mag (pay_mag), .pay_req (pay_req),
        .tx_sign (tx_sign), .tx_mag (tx_mag), .tx_scr (tx_scr), .sf_start (sf_start)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s f=%0d q=%0d actual=%0d expected=%0d", req, bf + 1, bq + 1, act, exp);
        end
    endtask

    // one quat step: drive at negedge, check the quat at the following negedge
    task automatic step();
        int          nq, nf;
        logic [1:0]  s_pay;
        logic        s_act, s_dea, s_uoa, s_aib, s_febe;
        logic [11:0] s_crc;
        logic [1:0]  e;
        logic        e_scr;
        int          k, c;
        lfsr     = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        pay_sign = lfsr[0];
        pay_mag  = lfsr[5];
        #0.1;
        nq = (bq == 119) ? 0 : bq + 1;
        nf = (bq == 119) ? ((bf == 7) ? 0 : bf + 1) : bf;
        chk("R4 pay_req", int'(pay_req), int'(nq >= 9 && nq <= 116));
        s_pay = {pay_sign, pay_mag};
        s_act = act_bit; s_dea = dea_bit; s_uoa = uoa_bit; s_aib = aib_bit;
        s_febe = febe_bit; s_crc = crc_bits;
        if (nq == 0 && (nf == 0 || nf == 4)) exp_eoc = eoc_word;
        @(posedge clk);
        @(negedge clk);
        cyc++;
        bq = nq;
        bf = nf;
        k = bf % 4;
        e_scr = 1'b1;
        if (bq < 9) begin
            e = PAT[17 - 2*bq -: 2];
            if (bf == 0) e[1] = ~e[1];
            e_scr = 1'b0;
            chk("R3 sync quat", int'({tx_sign, tx_mag}), int'(e));
        end else if (bq <= 116) begin
            chk("R4 payload quat", int'({tx_sign, tx_mag}), int'(s_pay));
        end else if (bq == 117) begin
            chk("R6 R7 eoc quat118", int'({tx_sign, tx_mag}),
                int'({exp_eoc[11 - 3*k], exp_eoc[10 - 3*k]}));
        end else if (bq == 118) begin
            chk("R6 R7 eoc quat119 sign", int'(tx_sign), int'(exp_eoc[9 - 3*k]));
            case (bf)
                0: e[0] = s_act;
                5: e[0] = s_dea;
                6: e[0] = s_uoa;
                7: e[0] = s_aib;
                default: e[0] = 1'b1;
            endcase
            chk("R8 R11 M4 bit", int'(tx_mag), int'(e[0]));
        end else begin
            if (bf == 0) begin
                chk("R9 reserved quat120", int'({tx_sign, tx_mag}), 3);
            end else if (bf == 1) begin
                chk("R9 R11 febe quat120", int'({tx_sign, tx_mag}), int'({1'b1, s_febe}));
            end else begin
                c = 11 - 2*(bf - 2);
                chk("R10 R11 crc quat120", int'({tx_sign, tx_mag}), int'({s_crc[c], s_crc[c-1]}));
            end
        end
        chk("R5 scramble flag", int'(tx_scr), int'(e_scr));
        chk("R2 sf_start", int'(sf_start), int'(bq == 0 && bf == 0));
        if (sf_start) begin
            if (last_sf >= 0) chk("R2 superframe period", cyc - last_sf, 960);
            last_sf = cyc;
        end
    endtask

    task automatic run_quats(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic t_reset();
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R1 reset outputs", int'({tx_sign, tx_mag, tx_scr, sf_start}), 0);
        end
        rst_n = 1'b1;
        step();
        chk("R1 first quat is superframe start", int'(sf_start), 1);
    endtask

    task automatic t_superframe_a();
        eoc_word = 12'hA5C; act_bit = 1'b1; dea_bit = 1'b0; uoa_bit = 1'b1; aib_bit = 1'b0;
        febe_bit = 1'b0; crc_bits = 12'h9B3;
        run_quats(959);
    endtask

    task automatic t_superframe_b();
        eoc_word = 12'h3A6; act_bit = 1'b0; dea_bit = 1'b1; uoa_bit = 1'b0; aib_bit = 1'b1;
        febe_bit = 1'b1; crc_bits = 12'h64C;
        run_quats(960);
    endtask

    // R7: eoc changes mid-frame must not reach the line before the next half-superframe edge
    task automatic t_eoc_ignore();
        for (int i = 0; i < 1920; i++) begin
            if (bq == 60) eoc_word = eoc_word ^ 12'hFFF ^ 12'(i);
            if (bq == 100) crc_bits = ~crc_bits;
            step();
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_superframe_a();
        t_superframe_b();
        t_eoc_ignore();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule